// File: doc/BRIEF.md
# Command-Data Phase Register Port

This block is the slave side of a 16-bit parallel host bus. The bus has a chip select, one phase-select line, and separate active-low read and write strobes. No register address lines reach the block. The host first writes a command word that names a target. It then moves data through one or more data phases on the same 16-bit path. The port holds a set of 16-bit registers, a set of 32-bit registers and a small word buffer, and it decides for each data phase which of these it touches.

The number of data phases depends on the target:

- A 16-bit register takes one data phase.
- A 32-bit register takes two, low half first.
- The buffer window takes any number of phases, each advancing a word pointer.

All bus inputs are brought into the core clock through synchronizers. A write or the end of a read takes effect when the strobe returns high. Read data is presented once the strobe has gone low.

Top module: `cdp_port`

## Requirements
- R1: A command phase is a write strobe with chip select low and `bus_sel` high. Its 16-bit data word picks the target:
  - 0x0010+i selects 16-bit register i (i < NUM_R16).
  - 0x0020+j selects 32-bit register j (j < NUM_R32).
  - 0x0040 selects the buffer window.
- R2: After a 16-bit register command, one data phase (`bus_sel` low) writes or reads that register.
- R3: A 32-bit write is a low-half phase followed by a high-half phase. The register keeps its old value until the high-half phase completes.
- R4: A 32-bit read returns bits 15:0 on the first data phase and bits 31:16 on the second.
- R5: The buffer command sets the word pointer to 0. Every buffer data phase, read or write, uses the word at the pointer and then advances it by one, wrapping after BUF_WORDS words.
- R6: Data phases beyond the count of a 16-bit or 32-bit target are ignored: writes change nothing and reads return 0.
- R7: Data phases after reset with no command, or after a command with an unknown code, are ignored and read 0.
- R8: Strobes seen while chip select is high have no effect.
- R9: After reset, `bus_dout` is 0 and every register and buffer word reads 0.
- R10: A new command restarts phase counting and abandons a half-finished 32-bit write or a buffer stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | 1 = command phase, 0 = data phase |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 16 | Data from host |
| bus_dout | output | 16 | Read data to host |

## Verification
The bench goes after the wide-register ordering. If the design swapped the halves, committed on the low phase, or let an abandoned low half leak into the register, the readback would differ from the computed pattern.

It also tests phases past the expected count and data phases with no valid command. A design that forgot its phase count would overwrite 16-bit registers or return live data where 0 is expected.

The buffer is filled and then read one word past its depth. This catches a pointer that fails to restart on a new command or fails to wrap. Strobes sent with chip select high must leave the registers untouched.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_R16, TGT_R32, TGT_BUF} tgt_kind_e;

  typedef struct packed {
    tgt_kind_e  kind;
    logic [3:0] idx;
  } tgt_t;

  localparam logic [11:0] GRP_R16 = 12'h001;
  localparam logic [11:0] GRP_R32 = 12'h002;
  localparam logic [15:0] CODE_BUF = 16'h0040;

  // Command word -> target; unknown codes map to TGT_NONE.
  function automatic tgt_t decode_cmd(logic [15:0] code, int n16, int n32);
    tgt_t t;
    t.kind = TGT_NONE;
    t.idx  = code[3:0];
    if (code == CODE_BUF) t.kind = TGT_BUF;
    else if (code[15:4] == GRP_R16 && int'(code[3:0]) < n16) t.kind = TGT_R16;
    else if (code[15:4] == GRP_R32 && int'(code[3:0]) < n32) t.kind = TGT_R32;
    return t;
  endfunction

  // Data phases allowed per target (0 = unbounded stream).
  function automatic logic [1:0] phase_limit(tgt_kind_e k);
    case (k)
      TGT_R16: return 2'd1;
      TGT_R32: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [15:0] ptr_next(logic [15:0] p, int depth);
    return (int'(p) + 1 >= depth) ? 16'd0 : p + 16'd1;
  endfunction
endpackage

// File: rtl/cdp_strobe_sync.sv
module cdp_strobe_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] prev_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      end else begin
        s1 <= async_in[b]; s2 <= s1; s3 <= s2;
      end
    end
    assign sync_out[b] = s2;
    assign prev_out[b] = s3;
  end
endmodule

// File: rtl/cdp_phase_ctrl.sv
module cdp_phase_ctrl
  import cdp_pkg::*;
#(
  parameter int NUM_R16 = 4,
  parameter int NUM_R32 = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_ev,
  input  logic        data_done,
  input  logic [15:0] cmd_code,
  output tgt_t        tgt,
  output logic [1:0]  phase,
  output logic        phase_ok
);
  logic [1:0] limit;
  assign limit    = phase_limit(tgt.kind);
  assign phase_ok = (tgt.kind == TGT_BUF) ||
                    (tgt.kind != TGT_NONE && phase < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt   <= '{kind: TGT_NONE, idx: 4'd0};
      phase <= 2'd0;
    end else if (cmd_ev) begin
      tgt   <= decode_cmd(cmd_code, NUM_R16, NUM_R32);
      phase <= 2'd0;
    end else if (data_done && phase_ok && tgt.kind != TGT_BUF) begin
      phase <= phase + 2'd1;
    end
  end

  assert_cmd_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ev |=> phase == 2'd0);
  assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
endmodule

// File: rtl/cdp_reg_store.sv
module cdp_reg_store
  import cdp_pkg::*;
#(
  parameter int NUM_R16   = 4,
  parameter int NUM_R32   = 2,
  parameter int BUF_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tgt_t        tgt,
  input  logic [1:0]  phase,
  input  logic        phase_ok,
  input  logic        buf_cmd,
  input  logic        wr_ev,
  input  logic        rd_start,
  input  logic        rd_end,
  input  logic [15:0] din,
  output logic [15:0] dout
);
  localparam int I16_W = NUM_R16 > 1 ? $clog2(NUM_R16) : 1;
  localparam int I32_W = NUM_R32 > 1 ? $clog2(NUM_R32) : 1;
  localparam int PTR_W = BUF_WORDS > 1 ? $clog2(BUF_WORDS) : 1;

  logic [15:0] r16_q [NUM_R16];
  logic [NUM_R32-1:0][31:0] r32_q;
  logic [15:0] buf_q [BUF_WORDS];
  logic [15:0] shadow_q;
  logic [31:0] snap_q;
  logic [15:0] ptr_q;

  logic [I16_W-1:0] i16;
  logic [I32_W-1:0] i32;
  logic [PTR_W-1:0] pw;
  assign i16 = tgt.idx[I16_W-1:0];
  assign i32 = tgt.idx[I32_W-1:0];
  assign pw  = ptr_q[PTR_W-1:0];

  // Named internal events
  logic is16, is32, isbuf;
  logic r16_wr, lower_wr, upper_wr, buf_wr, buf_step, stray_rd;
  assign is16     = phase_ok && tgt.kind == TGT_R16;
  assign is32     = phase_ok && tgt.kind == TGT_R32;
  assign isbuf    = phase_ok && tgt.kind == TGT_BUF;
  assign r16_wr   = wr_ev && is16;
  assign lower_wr = wr_ev && is32 && phase == 2'd0;
  assign upper_wr = wr_ev && is32 && phase == 2'd1;
  assign buf_wr   = wr_ev && isbuf;
  assign buf_step = (wr_ev || rd_end) && isbuf;
  assign stray_rd = rd_start && !phase_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_R16; k++) r16_q[k] <= '0;
      for (int k = 0; k < BUF_WORDS; k++) buf_q[k] <= '0;
      r32_q    <= '0;
      shadow_q <= '0;
      snap_q   <= '0;
      ptr_q    <= '0;
      dout     <= '0;
    end else begin
      if (r16_wr)   r16_q[i16] <= din;
      if (lower_wr) shadow_q <= din;
      if (upper_wr) r32_q[i32] <= {din, shadow_q};
      if (buf_wr)   buf_q[pw] <= din;
      if (buf_cmd)       ptr_q <= '0;
      else if (buf_step) ptr_q <= ptr_next(ptr_q, BUF_WORDS);
      if (rd_start) begin
        if (is16) dout <= r16_q[i16];
        else if (is32 && phase == 2'd0) begin
          snap_q <= r32_q[i32];
          dout   <= r32_q[i32][15:0];
        end
        else if (is32) dout <= snap_q[31:16];
        else if (isbuf) dout <= buf_q[pw];
        else dout <= '0;
      end
    end
  end

  assert_commit_on_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r32_q) |-> $past(upper_wr));
  assert_ptr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_q) |-> $past(buf_cmd || buf_step));
  assert_stray_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stray_rd |=> dout == 16'd0);
endmodule

// File: rtl/cdp_port.sv
module cdp_port
  import cdp_pkg::*;
#(
  parameter int NUM_R16   = 4,
  parameter int NUM_R32   = 2,
  parameter int BUF_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs_n,
  input  logic        bus_sel,
  input  logic        bus_rd_n,
  input  logic        bus_wr_n,
  input  logic [15:0] bus_din,
  output logic [15:0] bus_dout
);
  logic [3:0] s, p;
  cdp_strobe_sync #(.W(4)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .async_in({bus_cs_n, bus_sel, bus_rd_n, bus_wr_n}),
    .sync_out(s), .prev_out(p)
  );

  logic chip_on, sel_s, wr_rise, rd_fall, rd_rise;
  assign chip_on = !s[3];
  assign sel_s   = s[2];
  assign wr_rise = s[0] && !p[0];
  assign rd_fall = !s[1] && p[1];
  assign rd_rise = s[1] && !p[1];

  logic cmd_ev, wr_ev, rd_start, rd_end, buf_cmd;
  assign cmd_ev   = chip_on && sel_s && wr_rise;
  assign wr_ev    = chip_on && !sel_s && wr_rise;
  assign rd_start = chip_on && !sel_s && rd_fall;
  assign rd_end   = chip_on && !sel_s && rd_rise;
  assign buf_cmd  = cmd_ev && bus_din == CODE_BUF;

  tgt_t       tgt;
  logic [1:0] phase;
  logic       phase_ok;

  cdp_phase_ctrl #(.NUM_R16(NUM_R16), .NUM_R32(NUM_R32)) phase_i (
    .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev),
    .data_done(wr_ev || rd_end), .cmd_code(bus_din),
    .tgt(tgt), .phase(phase), .phase_ok(phase_ok)
  );

  cdp_reg_store #(.NUM_R16(NUM_R16), .NUM_R32(NUM_R32), .BUF_WORDS(BUF_WORDS)) store_i (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .phase(phase), .phase_ok(phase_ok),
    .buf_cmd(buf_cmd), .wr_ev(wr_ev), .rd_start(rd_start), .rd_end(rd_end),
    .din(bus_din), .dout(bus_dout)
  );

  assert_single_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ev, wr_ev, rd_start, rd_end}));
  assert_no_effect_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_on |=> $stable(phase) && $stable(bus_dout));
endmodule

// File: tb/cdp_port_tb_top.sv
module cdp_port_tb_top;
  localparam int N16 = 4, N32 = 2, NBUF = 16;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sel = 0, rd_n = 1, wr_n = 1;
  logic [15:0] din = 0, dout;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cdp_port #(.NUM_R16(N16), .NUM_R32(N32), .BUF_WORDS(NBUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_sel(sel),
    .bus_rd_n(rd_n), .bus_wr_n(wr_n), .bus_din(din), .bus_dout(dout));

  function automatic logic [15:0] pat16(int i); return 16'h1234 * (i + 3) ^ 16'h0F0F; endfunction
  function automatic logic [31:0] pat32(int j); return 32'hDEAD_0001 + 32'h0101_1010 * j; endfunction
  function automatic logic [15:0] patb(int k); return 16'hB000 | 16'(k * 37 + 5); endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(bit is_cmd, bit is_rd, logic [15:0] d, bit desel, output logic [15:0] q);
    @(negedge clk);
    cs_n = desel; sel = is_cmd; din = d;
    @(negedge clk);
    if (is_rd) rd_n = 0; else wr_n = 0;
    repeat (6) @(negedge clk);
    q = dout;
    rd_n = 1; wr_n = 1;
    repeat (6) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic cmd(logic [15:0] c); logic [15:0] q; strobe(1, 0, c, 0, q); endtask
  task automatic wr(logic [15:0] d); logic [15:0] q; strobe(0, 0, d, 0, q); endtask
  task automatic rd(output logic [15:0] q); strobe(0, 1, 16'h0, 0, q); endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q, q2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R9 reset dout", dout, 16'h0);
    // R7: data phases with no command
    wr(16'hFFFF); rd(q); check("R7 no command read", q, 16'h0);
    // R9: registers start at zero
    cmd(16'h0011); rd(q); check("R9 reset reg", q, 16'h0);
    // R2 sweep over 16-bit registers
    for (int i = 0; i < N16; i++) begin cmd(16'h0010 + 16'(i)); wr(pat16(i)); end
    for (int i = 0; i < N16; i++) begin cmd(16'h0010 + 16'(i)); rd(q); check("R2 r16 readback", q, pat16(i)); end
    // R6: extra phases on 16-bit register
    cmd(16'h0010); wr(16'h5555); wr(16'h6666);
    cmd(16'h0010); rd(q); rd(q2);
    check("R6 extra write ignored", q, 16'h5555);
    check("R6 extra read zero", q2, 16'h0);
    // R3/R4 sweep over 32-bit registers
    for (int j = 0; j < N32; j++) begin
      cmd(16'h0020 + 16'(j)); wr(pat32(j)[15:0]); wr(pat32(j)[31:16]);
    end
    for (int j = 0; j < N32; j++) begin
      cmd(16'h0020 + 16'(j)); rd(q); rd(q2);
      check("R4 r32 low half", q, pat32(j)[15:0]);
      check("R4 r32 high half", q2, pat32(j)[31:16]);
      rd(q); check("R6 r32 third read zero", q, 16'h0);
    end
    // R3/R10: abandoned low half does not commit
    cmd(16'h0020); wr(16'hAAAA);
    cmd(16'h0020); rd(q); check("R3 low half alone no commit", q, pat32(0)[15:0]);
    cmd(16'h0021); wr(16'h7777); cmd(16'h0013); wr(16'h4321);
    cmd(16'h0021); rd(q); rd(q2);
    check("R10 abandoned write low", q, pat32(1)[15:0]);
    check("R10 abandoned write high", q2, pat32(1)[31:16]);
    // R7: unknown code
    cmd(16'h0033); wr(16'h9999); rd(q); check("R7 unknown code read", q, 16'h0);
    cmd(16'h0014); rd(q); check("R7 out-of-range r16 code", q, 16'h0);
    cmd(16'h0011); rd(q); check("R7 unknown write clobbered nothing", q, pat16(1));
    // R5: buffer fill and read with wrap
    cmd(16'h0040);
    for (int k = 0; k < NBUF; k++) wr(patb(k));
    cmd(16'h0040);
    for (int k = 0; k <= NBUF; k++) begin rd(q); check("R5 buffer stream", q, patb(k % NBUF)); end
    // R10: new command restarts buffer stream
    cmd(16'h0040); rd(q); rd(q); rd(q);
    cmd(16'h0040); rd(q); check("R10 stream restart", q, patb(0));
    // R8: deselected strobes ignored
    strobe(1, 0, 16'h0012, 1, q); strobe(0, 0, 16'hEEEE, 1, q);
    cmd(16'h0012); rd(q); check("R8 deselected ignored", q, pat16(2));
    // R1: command decodes both groups
    cmd(16'h0013); rd(q); check("R1 command select r16", q, 16'h4321);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule